// File: doc/BRIEF.md
# Display Pixel Input FIFO with Burst Refill Requests

This block is the five-word staging buffer between a display controller's memory-fetch DMA channel and its pixel unpacker. Words arrive from the DMA on a valid/ready write port and leave on a valid/ready read port, always from the bottom slot. Every read moves the remaining words down one slot. When four or more of the five slots are empty, the block asks the DMA for a refill. Each refill is a four-word burst, so one slot is never filled by a refill.

The request is held until the DMA acknowledges it. The acknowledge comes in the same cycle as the first burst word. No new request is raised until four words of that burst have been accepted. Requests are issued only after an initialisation pulse has been seen while the block is enabled. Removing the enable clears all stored words, drops the request and the armed state, and keeps the status bit as it was.

If the consumer asks for a word while the FIFO is empty, the block returns zero and the stored contents do not change. This event sets a sticky underrun bit, which drives an interrupt when the interrupt enable is high. Software clears the bit with a write-one-to-clear strobe.

Back-pressure rules:
- The write side is ready only while the block is enabled and holds fewer than five words.
- A write is taken when `wr_valid` and `wr_ready` are both high.
- The read side offers a word while the block is enabled and not empty.
- The consumer raises `rd_ready` only when it needs a word. `rd_ready` high with `rd_valid` low is an underrun.

Top module: `dpx_fifo`

## Requirements
- R1: The FIFO stores at most five 32-bit words. `wr_ready` is high exactly when `en` is high and fewer than five words are held. A `wr_valid` while `wr_ready` is low is ignored and stores nothing.
- R2: Words leave in arrival order. `rd_data` shows the oldest stored word while `rd_valid` is high, and a push in the same cycle as a pop lands behind the words that remain.
- R3: `dma_req` stays low after reset, and after every re-enable, until an `init` pulse has been sampled while `en` is high.
- R4: Once armed and idle, `dma_req` rises one cycle after the stored word count is one or zero, that is, four or more slots are free.
- R5: `dma_req` stays high until the cycle in which `dma_ack` is sampled high. It then falls and stays low until four words have been accepted, counting the word taken in the acknowledge cycle.
- R6: `rd_ready` high while `en` is high and the FIFO is empty sets `st_underrun` on the next edge. `rd_data` is zero in that cycle and no stored word changes.
- R7: `st_underrun` stays set until a cycle with `st_clr` high and no new underrun. A new underrun in the same cycle as `st_clr` keeps the bit set.
- R8: `irq` is high exactly when `st_underrun` and `irq_en` are both high.
- R9: While `en` is low, every stored word is dropped at the next edge, `rd_valid` and `dma_req` are low, the armed state is lost, and `st_underrun` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Block enable; low flushes and disarms |
| init | input | 1 | Initialisation pulse that arms requests |
| dma_req | output | 1 | Refill service request to the DMA |
| dma_ack | input | 1 | DMA acknowledge, given with the first burst word |
| wr_valid | input | 1 | Write word valid |
| wr_ready | output | 1 | Write slot available |
| wr_data | input | 32 | Write word |
| rd_valid | output | 1 | Bottom word available |
| rd_ready | input | 1 | Consumer wants a word |
| rd_data | output | 32 | Bottom word, zero when empty |
| st_underrun | output | 1 | Sticky underrun status |
| st_clr | input | 1 | Write-one-to-clear strobe for the status |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Underrun interrupt |

## Verification
The hardest behaviour to reach is a refill burst that arrives slowly while the consumer keeps draining. In that case the word count falls back to one or zero in the middle of a burst, and the request must still stay low until the fourth word has been accepted. The random phase models a DMA that acknowledges after a random delay and drops words with gaps, while the consumer reads at a high rate. This produces mid-burst low-water crossings and underruns. Occasional disable windows, each followed by a fresh `init`, exercise flushes that cut a burst short.

// File: rtl/dpx_pkg.sv
package dpx_pkg;

  // refill request sequencing
  typedef enum logic [1:0] {
    RQ_IDLE  = 2'd0,
    RQ_WAIT  = 2'd1,
    RQ_BURST = 2'd2
  } rq_state_e;

endpackage

// File: rtl/dpx_store.sv
module dpx_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 5,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  fill_cnt,
  output logic [DATA_W-1:0] bottom
);

  logic [DEPTH-1:0][DATA_W-1:0] slot_q;
  logic [DEPTH-1:0][DATA_W-1:0] slot_d;
  logic [CNT_W-1:0]             cnt_q;
  logic [CNT_W-1:0]             wpos;

  // a pop frees the bottom slot first, so the new word lands one lower
  assign wpos = pop ? (cnt_q - CNT_W'(1)) : cnt_q;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic [DATA_W-1:0] moved;
    if (gi == DEPTH - 1) begin : g_top
      assign moved = pop ? '0 : slot_q[gi];
    end else begin : g_mid
      assign moved = pop ? slot_q[gi+1] : slot_q[gi];
    end
    assign slot_d[gi] = flush ? '0 :
                        (push && (wpos == CNT_W'(gi))) ? wr_data : moved;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
      cnt_q  <= '0;
    end else begin
      slot_q <= slot_d;
      if (flush)
        cnt_q <= '0;
      else if (push && !pop)
        cnt_q <= cnt_q + CNT_W'(1);
      else if (pop && !push)
        cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign fill_cnt = cnt_q;
  assign bottom   = slot_q[0];

endmodule

// File: rtl/dpx_req_ctl.sv
module dpx_req_ctl
  import dpx_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int BURST = 4,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             init,
  input  logic [CNT_W-1:0] fill_cnt,
  input  logic             push,
  input  logic             dma_ack,
  output logic             dma_req
);

  localparam int LOW_MARK = DEPTH - BURST;
  localparam int WORD_W   = $clog2(BURST + 1);

  rq_state_e         st_q;
  logic [WORD_W-1:0] words_q;
  logic              armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= RQ_IDLE;
      words_q <= '0;
      armed_q <= 1'b0;
    end else if (!en) begin
      st_q    <= RQ_IDLE;
      words_q <= '0;
      armed_q <= 1'b0;
    end else begin
      if (init)
        armed_q <= 1'b1;
      case (st_q)
        RQ_IDLE: begin
          if (armed_q && (fill_cnt <= CNT_W'(LOW_MARK)))
            st_q <= RQ_WAIT;
        end
        RQ_WAIT: begin
          if (dma_ack) begin
            st_q    <= RQ_BURST;
            words_q <= push ? WORD_W'(1) : '0;
          end
        end
        RQ_BURST: begin
          if (push) begin
            if (words_q == WORD_W'(BURST - 1)) begin
              st_q    <= RQ_IDLE;
              words_q <= '0;
            end else begin
              words_q <= words_q + WORD_W'(1);
            end
          end
        end
        default: st_q <= RQ_IDLE;
      endcase
    end
  end

  assign dma_req = (st_q == RQ_WAIT);

endmodule

// File: rtl/dpx_status.sv
module dpx_status (
  input  logic clk,
  input  logic rst_n,
  input  logic underrun_evt,
  input  logic clr,
  input  logic irq_en,
  output logic st_underrun,
  output logic irq
);

  logic st_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      st_q <= 1'b0;
    else if (underrun_evt)
      st_q <= 1'b1;
    else if (clr)
      st_q <= 1'b0;
  end

  assign st_underrun = st_q;
  assign irq         = st_q & irq_en;

endmodule

// File: rtl/dpx_fifo.sv
module dpx_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 5,
  parameter int BURST  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              init,
  output logic              dma_req,
  input  logic              dma_ack,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              st_underrun,
  input  logic              st_clr,
  input  logic              irq_en,
  output logic              irq
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]  fill_cnt;
  logic [DATA_W-1:0] bottom;
  logic              push;
  logic              pop;
  logic              not_empty;
  logic              underrun_evt;

  assign not_empty    = (fill_cnt != '0);
  assign wr_ready     = en && (fill_cnt < CNT_W'(DEPTH));
  assign rd_valid     = en && not_empty;
  assign push         = wr_valid && wr_ready;
  assign pop          = rd_ready && rd_valid;
  assign underrun_evt = en && rd_ready && !not_empty;
  assign rd_data      = rd_valid ? bottom : '0;

  dpx_store #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (!en),
    .push     (push),
    .pop      (pop),
    .wr_data  (wr_data),
    .fill_cnt (fill_cnt),
    .bottom   (bottom)
  );

  dpx_req_ctl #(
    .DEPTH (DEPTH),
    .BURST (BURST),
    .CNT_W (CNT_W)
  ) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .init     (init),
    .fill_cnt (fill_cnt),
    .push     (push),
    .dma_ack  (dma_ack),
    .dma_req  (dma_req)
  );

  dpx_status u_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .underrun_evt (underrun_evt),
    .clr          (st_clr),
    .irq_en       (irq_en),
    .st_underrun  (st_underrun),
    .irq          (irq)
  );

endmodule

// File: rtl/dpx_fifo_chk.sv
module dpx_fifo_chk #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 5,
  parameter int BURST  = 4,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              dma_req,
  input logic              dma_ack,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              st_underrun,
  input logic              st_clr,
  input logic              irq,
  input logic [CNT_W-1:0]  fill_cnt
);

  localparam int WORD_W = $clog2(BURST + 1);

  logic              in_burst;
  logic [WORD_W-1:0] seen;
  logic              wr_take;

  assign wr_take = wr_valid && wr_ready;

  // independent burst tracker seen from the DMA side
  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      in_burst <= 1'b0;
      seen     <= '0;
    end else if (dma_req && dma_ack) begin
      in_burst <= 1'b1;
      seen     <= wr_take ? WORD_W'(1) : '0;
    end else if (in_burst && wr_take) begin
      if (seen == WORD_W'(BURST - 1)) begin
        in_burst <= 1'b0;
        seen     <= '0;
      end else begin
        seen <= seen + WORD_W'(1);
      end
    end
  end

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CNT_W'(DEPTH));

  p_full_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt == CNT_W'(DEPTH)) |-> !wr_ready);

  p_bottom_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (!en || $stable(rd_data)));

  p_disarm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !dma_req);

  p_hold_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dma_req && !dma_ack) |=> (!en || dma_req));

  p_burst_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_burst |-> !dma_req);

  p_zero_on_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && !rd_valid) |-> (rd_data == '0));

  p_set_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_underrun) |-> $past(en && rd_ready && !rd_valid));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_underrun && !st_clr) |=> st_underrun);

  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> st_underrun);

  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (fill_cnt == '0));

endmodule

bind dpx_fifo dpx_fifo_chk #(
  .DATA_W (DATA_W),
  .DEPTH  (DEPTH),
  .BURST  (BURST),
  .CNT_W  (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (en),
  .dma_req     (dma_req),
  .dma_ack     (dma_ack),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .rd_valid    (rd_valid),
  .rd_ready    (rd_ready),
  .rd_data     (rd_data),
  .st_underrun (st_underrun),
  .st_clr      (st_clr),
  .irq         (irq),
  .fill_cnt    (fill_cnt)
);

// File: tb/dpx_fifo_tb.sv
`timescale 1ns/1ps
module dpx_fifo_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        init = 1'b0;
  logic        dma_ack = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_ready = 1'b0;
  logic        st_clr = 1'b0;
  logic        irq_en = 1'b0;
  logic        dma_req, wr_ready, rd_valid, st_underrun, irq;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference model state
  logic [31:0] mq[$];
  bit m_armed, m_req, m_burst, m_st;
  int m_words;

  always #2.5 clk = ~clk;

  dpx_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .init(init),
    .dma_req(dma_req), .dma_ack(dma_ack),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .st_underrun(st_underrun), .st_clr(st_clr), .irq_en(irq_en), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_wready();
    return en && (mq.size() < 5);
  endfunction

  function automatic logic [31:0] exp_bottom();
    return (en && mq.size() > 0) ? mq[0] : 32'h0;
  endfunction

  // apply the current inputs to the model, as the next edge will
  task automatic model_step();
    bit push, pop, evt;
    int sz;
    sz   = mq.size();
    push = wr_valid && exp_wready();
    pop  = en && rd_ready && (sz > 0);
    evt  = en && rd_ready && (sz == 0);
    if (!en) begin
      m_armed = 0; m_req = 0; m_burst = 0; m_words = 0;
      mq.delete();
    end else begin
      if (!m_req && !m_burst) begin
        if (m_armed && sz <= 1) m_req = 1;
      end else if (m_req) begin
        if (dma_ack) begin m_req = 0; m_burst = 1; m_words = push ? 1 : 0; end
      end else if (push) begin
        if (m_words == 3) begin m_burst = 0; m_words = 0; end
        else m_words++;
      end
      if (init) m_armed = 1;
      if (pop) void'(mq.pop_front());
      if (push) mq.push_back(wr_data);
    end
    if (evt) m_st = 1;
    else if (st_clr) m_st = 0;
  endtask

  task automatic compare_all();
    chk("R2 rd_valid", {31'b0, rd_valid}, {31'b0, (en && mq.size() > 0)});
    chk("R2 rd_data", rd_data, exp_bottom());
    chk("R1 wr_ready", {31'b0, wr_ready}, {31'b0, exp_wready()});
    chk("R4 dma_req", {31'b0, dma_req}, {31'b0, m_req});
    chk("R6 st_underrun", {31'b0, st_underrun}, {31'b0, m_st});
    chk("R8 irq", {31'b0, irq}, {31'b0, (m_st && irq_en)});
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] seed_dummy;
    logic [31:0] words[6];
    int off_cnt, dleft;
    bit acc;
    seed_dummy = $urandom(32'd20241);

    // reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_armed = 0; m_req = 0; m_burst = 0; m_st = 0; m_words = 0;
    compare_all();

    // R3: enabled but not initialised: no request even when empty
    en = 1'b1;
    repeat (6) tick();
    chk("R3 no request before init", {31'b0, dma_req}, 32'd0);
    init = 1'b1; tick(); init = 1'b0; tick();
    chk("R3 request after init", {31'b0, dma_req}, 32'd1);

    // R5: request held until acknowledge, then quiet for the burst
    repeat (3) tick();
    chk("R5 held without ack", {31'b0, dma_req}, 32'd1);
    for (int i = 0; i < 4; i++) words[i] = 32'hA000_0000 + i;
    dma_ack = 1'b1; wr_valid = 1'b1; wr_data = words[0]; tick();
    dma_ack = 1'b0;
    for (int i = 1; i < 4; i++) begin
      chk("R5 quiet inside burst", {31'b0, dma_req}, 32'd0);
      wr_data = words[i]; tick();
    end
    wr_valid = 1'b0; tick();
    chk("R5 no request at four held", {31'b0, dma_req}, 32'd0);

    // R2: drain in arrival order
    rd_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      chk("R2 order", rd_data, words[i]);
      tick();
    end

    // R6: read while empty
    chk("R6 empty before underrun", {31'b0, rd_valid}, 32'd0);
    tick();
    chk("R6 status set", {31'b0, st_underrun}, 32'd1);
    chk("R6 zero data", rd_data, 32'd0);
    rd_ready = 1'b0;
    irq_en = 1'b0; tick();
    chk("R8 masked", {31'b0, irq}, 32'd0);
    irq_en = 1'b1; tick();
    chk("R8 unmasked", {31'b0, irq}, 32'd1);

    // R7: clear loses against a new underrun, then clears
    st_clr = 1'b1; rd_ready = 1'b1; tick();
    chk("R7 set beats clear", {31'b0, st_underrun}, 32'd1);
    rd_ready = 1'b0; tick();
    chk("R7 cleared", {31'b0, st_underrun}, 32'd0);
    st_clr = 1'b0;

    // R1: fill to five, a sixth write is dropped
    wr_valid = 1'b1;
    for (int i = 0; i < 6; i++) begin
      words[i] = 32'hB000_0000 + i;
      wr_data = words[i]; tick();
    end
    wr_valid = 1'b0;
    chk("R1 full not ready", {31'b0, wr_ready}, 32'd0);
    rd_ready = 1'b1;
    for (int i = 0; i < 5; i++) begin
      chk("R1 stored word", rd_data, words[i]);
      tick();
    end
    chk("R1 sixth word absent", {31'b0, rd_valid}, 32'd0);

    // R9: disable flushes, keeps status, drops request and arming
    tick();
    rd_ready = 1'b0;
    wr_valid = 1'b1; wr_data = 32'hC0DE_0001; tick(); tick(); wr_valid = 1'b0;
    en = 1'b0; tick();
    chk("R9 no valid", {31'b0, rd_valid}, 32'd0);
    chk("R9 no request", {31'b0, dma_req}, 32'd0);
    chk("R9 status kept", {31'b0, st_underrun}, 32'd1);
    en = 1'b1; repeat (4) tick();
    chk("R9 flushed", {31'b0, rd_valid}, 32'd0);
    chk("R3 disarmed after re-enable", {31'b0, dma_req}, 32'd0);
    st_clr = 1'b1; tick(); st_clr = 1'b0;

    // random phase with a DMA model that answers requests
    init = 1'b1; tick(); init = 1'b0;
    off_cnt = 0; dleft = 0;
    for (int n = 0; n < 6000; n++) begin
      init = 1'b0;
      if (!en) begin
        off_cnt--;
        if (off_cnt <= 0) begin en = 1'b1; init = 1'b1; end
      end else if ($urandom % 600 == 0) begin
        en = 1'b0; off_cnt = 1 + ($urandom % 4);
      end
      rd_ready = ($urandom % 100) < ((n / 1000) % 2 == 0 ? 30 : 55);
      st_clr   = ($urandom % 40 == 0);
      if ($urandom % 50 == 0) irq_en = ~irq_en;
      dma_ack = 1'b0; wr_valid = 1'b0;
      if (!en) begin
        dleft = 0;
      end else if (dleft == 0) begin
        if (dma_req && ($urandom % 3 == 0)) begin
          dma_ack = 1'b1; wr_valid = 1'b1; wr_data = $urandom;
        end
      end else if ($urandom % 4 != 0) begin
        wr_valid = 1'b1; wr_data = $urandom;
      end
      acc = wr_valid && exp_wready();
      if (dma_ack) dleft = acc ? 3 : 4;
      else if (acc && dleft > 0) dleft--;
      tick();
    end
    finish_run();
  end

endmodule